// File: doc/BRIEF.md
# Maintenance Port-Write Packet Composer

This block builds one outbound maintenance port-write packet at a time from values a host places in a small register space. Through a single-cycle write port the host loads a payload of up to 64 bytes into a transmit buffer. It also loads a command word carrying the target device identifier, a two-bit priority, a byte count and a start bit. The format and transaction-type codes, the two size-encoding fields and the reserved fields are all produced inside the block. None of them comes from the host.

When the host writes the command word with the start bit set and a legal byte count, the block raises a busy flag and sends the packet on a 64-bit valid/ready stream. The header beat goes first, followed by the payload beats. A start marker is set on the header and an end marker on the final payload beat. The busy flag falls once the final beat has been taken. The host can poll it to learn when the buffer may be refilled. While busy is high, every host write is dropped. An illegal byte count sends nothing and sets an error flag instead.

Top module: `pw_tx_composer`

## Requirements
- R1: In the header beat (the beat flagged start), bits [61:58] hold the format code 4'b1000 and bits [41:38] hold the transaction code 4'b0100.
- R2: The byte count sets header bits [37:34] (size code) and bit [33] (word pointer): 8 gives 4'b1011/0, 16 gives 4'b1011/1, 32 gives 4'b1100/0, and 64 gives 4'b1100/1.
- R3: Header bits [63:62] carry the priority and bits [57:42] carry the destination identifier. Bits [32:0], which cover the source transaction tag and the configuration offset, are always zero.
- R4: The header is followed by count/8 payload beats. Payload beat k is {buffer word 2k+1, buffer word 2k}. Buffer word i is written at address 16+i.
- R5: A command write to address 0 with bit 31 set and a count in bits [24:18] other than 8, 16, 32 or 64 sends no beat, leaves busy low and sets the error flag. The next accepted command with a legal count clears the flag.
- R6: Busy rises on the clock edge that accepts a legal start command. It stays high until the edge that accepts the end-flagged beat, and it is low in the next cycle.
- R7: Start is set only on the header beat and end only on the last payload beat. The two are never set together.
- R8: While valid is high and ready is low, valid, data, start and end hold their values into the next cycle.
- R9: Host writes to the buffer or to the command word are ignored while busy is high, including a write in the cycle of the final beat's acceptance.
- R10: After reset, valid, busy, error, start and end are all low.
- R11: Valid rises, carrying the header, in the cycle right after the start command is written. In the command word, bits [15:0] are the destination and bits [17:16] are the priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Word address: 0 is the command word, 16..31 are the buffer |
| host_wr_data | input | 32 | Host write data |
| pkt_busy | output | 1 | Packet pending or being sent |
| size_err | output | 1 | Last start command had an illegal byte count |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 64 | Stream beat |
| tx_sop | output | 1 | Header beat marker |
| tx_eop | output | 1 | Last beat marker |

## Verification
The case that needs care is a host write landing in the same cycle that the sink accepts the final payload beat. The busy flag is still high at that edge, so the write has to be dropped. It must not start a second packet. The bench stalls the sink on the end beat, then raises ready and issues a fresh start command on the same falling edge. It judges the result by requiring that busy and valid are both low afterwards and stay low for several cycles. A second case writes both the buffer and the command word while a packet waits under backpressure, and then checks that every beat still carries the original contents.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam logic [3:0] PW_FMT_CODE = 4'b1000;
  localparam logic [3:0] PW_TXN_CODE = 4'b0100;

  typedef struct packed {
    logic [15:0] dest;
    logic [1:0]  prio;
    logic [3:0]  size_code;
    logic        word_ptr;
  } pw_cmd_t;

  function automatic logic [63:0] pw_header(input pw_cmd_t c);
    logic [63:0] h;
    h          = '0;
    h[63:62]   = c.prio;
    h[61:58]   = PW_FMT_CODE;
    h[57:42]   = c.dest;
    h[41:38]   = PW_TXN_CODE;
    h[37:34]   = c.size_code;
    h[33]      = c.word_ptr;
    return h;
  endfunction

endpackage

// File: rtl/pw_size_enc.sv
module pw_size_enc #(
  parameter int IDX_W = 4
) (
  input  logic [6:0]       nbytes,
  output logic             legal,
  output logic [3:0]       size_code,
  output logic             word_ptr,
  output logic [IDX_W-1:0] last_idx
);

  always_comb begin
    legal     = 1'b1;
    size_code = 4'b1011;
    word_ptr  = 1'b0;
    last_idx  = IDX_W'(1);
    unique case (nbytes)
      7'd8:    begin size_code = 4'b1011; word_ptr = 1'b0; last_idx = IDX_W'(1); end
      7'd16:   begin size_code = 4'b1011; word_ptr = 1'b1; last_idx = IDX_W'(2); end
      7'd32:   begin size_code = 4'b1100; word_ptr = 1'b0; last_idx = IDX_W'(4); end
      7'd64:   begin size_code = 4'b1100; word_ptr = 1'b1; last_idx = IDX_W'(8); end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/pw_regs.sv
module pw_regs
  import pw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 busy,
  output logic                 go,
  output pw_cmd_t              cmd,
  output logic [IDX_W-1:0]     last_idx,
  output logic                 err,
  output logic [WORDS*32-1:0]  buf_flat
);

  localparam int WIDX = $clog2(WORDS);

  logic             accept;
  logic             ctl_hit;
  logic             start_req;
  logic             buf_hit;
  logic [WIDX-1:0]  buf_sel;
  logic             enc_legal;
  logic [3:0]       enc_code;
  logic             enc_ptr;
  logic [IDX_W-1:0] enc_last;

  pw_cmd_t          cmd_d;
  logic [IDX_W-1:0] last_d;
  logic             err_d;

  pw_size_enc #(.IDX_W(IDX_W)) u_enc (
    .nbytes   (wr_data[24:18]),
    .legal    (enc_legal),
    .size_code(enc_code),
    .word_ptr (enc_ptr),
    .last_idx (enc_last)
  );

  always_comb begin
    accept    = wr_en && !busy;
    ctl_hit   = accept && (wr_addr == '0);
    start_req = ctl_hit && wr_data[31];
    go        = start_req && enc_legal;
    buf_hit   = accept && (int'(wr_addr) >= WORDS) && (int'(wr_addr) < 2*WORDS);
    buf_sel   = wr_addr[WIDX-1:0];
  end

  always_comb begin
    cmd_d  = cmd;
    last_d = last_idx;
    err_d  = err;
    if (go) begin
      cmd_d.dest      = wr_data[15:0];
      cmd_d.prio      = wr_data[17:16];
      cmd_d.size_code = enc_code;
      cmd_d.word_ptr  = enc_ptr;
      last_d          = enc_last;
    end
    if (start_req) err_d = !enc_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= '0;
      last_idx <= '0;
      err      <= 1'b0;
    end else begin
      if (go) begin
        cmd      <= cmd_d;
        last_idx <= last_d;
      end
      if (start_req) err <= err_d;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic word_we;
    assign word_we = buf_hit && (buf_sel == WIDX'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_flat[g*32 +: 32] <= '0;
      else if (word_we) buf_flat[g*32 +: 32] <= wr_data;
    end
  end

endmodule

// File: rtl/pw_stream.sv
module pw_stream
  import pw_pkg::*;
#(
  parameter int BEATS = 8,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  pw_cmd_t               cmd,
  input  logic [IDX_W-1:0]      last_idx,
  input  logic [BEATS*64-1:0]   buf_flat,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [63:0]           out_data,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic                  busy
);

  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] pay_idx;
  logic [63:0]      beats [BEATS];
  logic             take;

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beats[g] = buf_flat[g*64 +: 64];
  end

  always_comb begin
    busy      = busy_q;
    out_valid = busy_q;
    out_sop   = busy_q && (idx_q == '0);
    out_eop   = busy_q && (idx_q == last_idx);
    pay_idx   = idx_q - IDX_W'(1);
    out_data  = (idx_q == '0) ? pw_header(cmd) : beats[pay_idx[BW-1:0]];
    take      = busy_q && out_ready;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (go) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (take) begin
      if (out_eop) busy_d = 1'b0;
      else         idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/pw_tx_composer.sv
module pw_tx_composer
  import pw_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [31:0]       host_wr_data,
  output logic              pkt_busy,
  output logic              size_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [63:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop
);

  localparam int WORDS = MAX_BYTES / 4;
  localparam int BEATS = MAX_BYTES / 8;
  localparam int IDX_W = $clog2(BEATS + 1);

  logic                go;
  pw_cmd_t             cmd;
  logic [IDX_W-1:0]    last_idx;
  logic [WORDS*32-1:0] buf_flat;
  logic                busy;

  pw_regs #(.ADDR_W(ADDR_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_en),
    .wr_addr (host_wr_addr),
    .wr_data (host_wr_data),
    .busy    (busy),
    .go      (go),
    .cmd     (cmd),
    .last_idx(last_idx),
    .err     (size_err),
    .buf_flat(buf_flat)
  );

  pw_stream #(.BEATS(BEATS), .IDX_W(IDX_W)) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cmd      (cmd),
    .last_idx (last_idx),
    .buf_flat (buf_flat),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .out_sop  (tx_sop),
    .out_eop  (tx_eop),
    .busy     (busy)
  );

  assign pkt_busy = busy;

endmodule

// File: rtl/pw_tx_chk.sv
module pw_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_busy,
  input logic        size_err,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop
);

  AST_HDR_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data[61:58] == 4'b1000 && tx_data[41:38] == 4'b0100); // R1

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data[37:34] == 4'b1011 || tx_data[37:34] == 4'b1100); // R2

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> tx_data[32:0] == 33'd0); // R3

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !tx_valid); // R5

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_busy) |-> $past(tx_valid && tx_ready && tx_eop)); // R6

  AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)); // R8

endmodule

bind pw_tx_composer pw_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pkt_busy(pkt_busy),
  .size_err(size_err),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .tx_data (tx_data),
  .tx_sop  (tx_sop),
  .tx_eop  (tx_eop)
);

// File: tb/sim_pw_tx_composer.sv
module sim_pw_tx_composer;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [4:0]  host_wr_addr;
  logic [31:0] host_wr_data;
  logic        pkt_busy, size_err, tx_valid, tx_ready, tx_sop, tx_eop;
  logic [63:0] tx_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // [6:0] byte count, [22:7] destination, [24:23] priority, [32:25] stall mask
  localparam logic [32:0] VEC [5] = '{
    {8'h00, 2'd0, 16'h1234, 7'd8},
    {8'h55, 2'd1, 16'hABCD, 7'd16},
    {8'h0F, 2'd2, 16'h0001, 7'd32},
    {8'hA3, 2'd3, 16'hFFFF, 7'd64},
    {8'h00, 2'd1, 16'h5A5A, 7'd64}
  };

  pw_tx_composer u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .pkt_busy(pkt_busy), .size_err(size_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      finish_up();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(input int seed, input int i);
    return (32'h1000_0000 * (seed + 1)) ^ (32'h0101_0101 * i) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [63:0] exp_hdr(input logic [15:0] d, input logic [1:0] p, input int n);
    logic [63:0] h;
    h = '0;
    h[63:62] = p;
    h[61:58] = 4'b1000;
    h[57:42] = d;
    h[41:38] = 4'b0100;
    h[37:34] = (n >= 32) ? 4'b1100 : 4'b1011;
    h[33]    = (n == 16 || n == 64);
    return h;
  endfunction

  task automatic host_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) host_write(5'(16 + i), word_val(seed, i));
  endtask

  function automatic logic [31:0] cmd_word(input logic [15:0] d, input logic [1:0] p, input int n);
    return {1'b1, 6'd0, 7'(n), p, d};
  endfunction

  // Receive one packet and compare every beat; caller has just issued the start command
  task automatic collect(input logic [15:0] d, input logic [1:0] p, input int n,
                         input logic [7:0] mask, input int seed);
    int nb = 0;
    int c  = 0;
    bit done = 0;
    bit held = 0;
    logic [63:0] hold_d = '0;
    logic [63:0] expd;
    #1;
    check(tx_valid && tx_sop, "R11 valid+sop after start", {62'd0, tx_valid, tx_sop}, 64'd3);
    check(pkt_busy, "R6 busy after start", {63'd0, pkt_busy}, 64'd1);
    while (!done) begin
      @(negedge clk);
      tx_ready = !mask[c % 8];
      c++;
      #1;
      if (held) check(tx_valid && tx_data == hold_d, "R8 hold under stall", tx_data, hold_d);
      held = tx_valid && !tx_ready;
      hold_d = tx_data;
      if (tx_valid && tx_ready) begin
        if (nb == 0) begin
          expd = exp_hdr(d, p, n);
          check(tx_data == expd, "R1/R2/R3 header", tx_data, expd);
          check(tx_sop && !tx_eop, "R7 header markers", {62'd0, tx_sop, tx_eop}, 64'd2);
        end else begin
          expd = {word_val(seed, 2*nb - 1), word_val(seed, 2*nb - 2)};
          check(tx_data == expd, "R4 payload beat", tx_data, expd);
          check(!tx_sop && (tx_eop == (nb == n/8)), "R7 payload markers",
                {62'd0, tx_sop, tx_eop}, {62'd0, 1'b0, nb == n/8});
        end
        if (tx_eop) done = 1;
        nb++;
      end
    end
    check(nb == n/8 + 1, "R4 beat count", 64'(nb), 64'(n/8 + 1));
    @(negedge clk);
    #1;
    check(!pkt_busy && !tx_valid, "R6 busy clears after end", {62'd0, pkt_busy, tx_valid}, 64'd0);
    tx_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_wr_en = 1'b0; host_wr_addr = '0; host_wr_data = '0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid && !pkt_busy && !size_err && !tx_sop && !tx_eop, "R10 reset state",
          {59'd0, tx_valid, pkt_busy, size_err, tx_sop, tx_eop}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table walk
    for (int v = 0; v < 5; v++) begin
      fill(v);
      host_write(5'd0, cmd_word(VEC[v][22:7], VEC[v][24:23], int'(VEC[v][6:0])));
      collect(VEC[v][22:7], VEC[v][24:23], int'(VEC[v][6:0]), VEC[v][32:25], v);
    end

    // R5: illegal counts
    host_write(5'd0, cmd_word(16'h2222, 2'd0, 24));
    #1;
    check(size_err && !pkt_busy, "R5 err on count 24", {62'd0, size_err, pkt_busy}, 64'd2);
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid, "R5 no beat for bad count", {63'd0, tx_valid}, 64'd0);
    host_write(5'd0, cmd_word(16'h2222, 2'd0, 0));
    #1;
    check(size_err && !tx_valid, "R5 err on count 0", {62'd0, size_err, tx_valid}, 64'd2);
    host_write(5'd0, cmd_word(16'h3030, 2'd2, 8));
    #1;
    check(!size_err, "R5 err cleared by legal start", {63'd0, size_err}, 64'd0);
    collect(16'h3030, 2'd2, 8, 8'h00, 4);

    // R9: writes while a packet waits under backpressure
    fill(7);
    host_write(5'd0, cmd_word(16'h4455, 2'd3, 16));
    host_write(5'd16, 32'hDEAD_BEEF);
    host_write(5'd17, 32'h0BAD_F00D);
    host_write(5'd0, cmd_word(16'h7777, 2'd0, 64));
    collect(16'h4455, 2'd3, 16, 8'h00, 7);

    // R9: start command in the same cycle as the final beat's acceptance
    host_write(5'd0, cmd_word(16'h0F0F, 2'd1, 8));
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    #1;
    check(tx_valid && tx_eop, "R7 end beat pending", {62'd0, tx_valid, tx_eop}, 64'd3);
    @(negedge clk);
    tx_ready = 1'b1;
    host_wr_en = 1'b1; host_wr_addr = 5'd0; host_wr_data = cmd_word(16'h1111, 2'd0, 16);
    @(negedge clk);
    host_wr_en = 1'b0; tx_ready = 1'b0;
    #1;
    check(!pkt_busy && !tx_valid, "R9 collision write dropped", {62'd0, pkt_busy, tx_valid}, 64'd0);
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid, "R9 no second packet", {63'd0, tx_valid}, 64'd0);

    finish_up();
  end

endmodule